// File: doc/BRIEF.md
# Inter-processor mailbox register block

The block gives one host processor a memory-mapped way to exchange short messages with three remote processors. Each remote link owns a bank of eight 32-bit message words and a doorbell register. A remote processor fills the words through its own write port and then rings the doorbell. The host reads the words, and may overwrite them, through a 32-bit register port. The host can also reach a small interrupt controller that latches one status bit per link, clears status bits on request, applies a per-link enable mask and drives one combined interrupt line.

The host address space is split into four 4 KiB banks, numbered 0 to 3. Bank 0 is the host's own slot. It has no message storage and holds the interrupt controller registers. Banks 1 to 3 hold the message banks of remote links 1 to 3. Status, clear and mask bit k belongs to link k+1, because the host's own slot is skipped in the numbering. In word 0 a nonzero value marks a message. In word 7 the value 0xDEADBEAF marks an acknowledge. Software interprets both values; the hardware only stores them.

Top module: `mbox_hub`

## Requirements
- R1: After reset, the status register, the mask register, every message word, every doorbell register and irq_o are zero.
- R2: A remote write to byte offset 0x14+4k (k = 0..7, where 0x30 is word 7) of link n stores the data. The host reads the same value at address n*0x1000 + 0x14+4k.
- R3: A remote write to doorbell offset 0x10 with bit 6 (message) or bit 7 (acknowledge) set sets status bit n-1 at that clock edge. The host reads status at address 0x0, with bits 2:0 used. A status bit stays set until it is cleared.
- R4: Doorbell bits 6 and 7 read as 1 for one cycle after the remote write and then clear themselves. Doorbell bits 5:0 hold their written value. The doorbell is read at n*0x1000 + 0x10, and host writes to it have no effect.
- R5: A host write to the clear register at address 0x4 clears each status bit written as 1 and leaves bits written as 0 unchanged. Writing 0xFF clears every bit. Reads of 0x4 return zero.
- R6: If a doorbell event and a clear of the same status bit fall in the same cycle, the status bit ends up set.
- R7: The mask register at address 0xC (bits 2:0, 1 = enabled) gates the interrupt. irq_o is the registered OR of (status AND mask). It rises one cycle after the status bit sets and falls one cycle after the bit is cleared or masked.
- R8: A host write to a message word replaces its content. This is how the receiver zeroes word 0 or word 7.
- R9: Reads from unmapped host addresses return zero, and writes to them change nothing. Unmapped addresses are other offsets of bank 0, offsets outside 0x10..0x30 in banks 1 to 3, misaligned offsets, and addresses at 0x4000 or above. A remote write outside 0x10..0x30 is also ignored.
- R10: If the host and the remote write the same message word in the same cycle, the remote data is kept.
- R11: A doorbell write with neither bit 6 nor bit 7 set leaves the status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hst_we_i | input | 1 | Host write strobe |
| hst_addr_i | input | 16 | Host byte address |
| hst_wdata_i | input | 32 | Host write data |
| hst_rdata_o | output | 32 | Host read data, combinational from hst_addr_i |
| rmt_we_i | input | 3 | Remote write strobe, one per link |
| rmt_off_i | input | 18 | Remote byte offset, 6 bits per link |
| rmt_wdata_i | input | 96 | Remote write data, 32 bits per link |
| irq_o | output | 1 | Combined interrupt to the host |

## Verification
On every cycle, the assertions check the following. A status bit holds when it is neither set nor cleared. A doorbell event always leaves its status bit set, including when a clear falls in the same cycle. Doorbell bits 6 and 7 fall back to zero one cycle later. irq_o follows the masked status with one cycle of delay. The bench's directed scenarios cover the rest: the address map, the mapping of link numbers to bits, the round trip of every word of a bank, the precedence between host and remote writes to the same word, and the silence of unmapped addresses.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned OFF_W = 6;

  localparam logic [OFF_W-1:0] OFF_STAT = 6'h00;
  localparam logic [OFF_W-1:0] OFF_CLR  = 6'h04;
  localparam logic [OFF_W-1:0] OFF_MASK = 6'h0C;
  localparam logic [OFF_W-1:0] OFF_DB   = 6'h10;
  localparam logic [OFF_W-1:0] OFF_LAST = 6'h30;

  localparam int unsigned DB_MSG_BIT = 6;
  localparam int unsigned DB_ACK_BIT = 7;

  typedef struct packed {
    logic       hit;
    logic [3:0] slot;  // 0 = doorbell, 1..8 = message word 0..7
  } slot_t;

  function automatic slot_t dec_slot(input logic [OFF_W-1:0] off);
    slot_t s;
    logic [OFF_W-1:0] rel;
    rel    = off - OFF_DB;
    s.hit  = (off[1:0] == 2'b00) && (off >= OFF_DB) && (off <= OFF_LAST);
    s.slot = rel[5:2];
    return s;
  endfunction
endpackage

// File: rtl/mbox_link.sv
module mbox_link
  import mbox_pkg::*;
#(
  parameter int unsigned DW     = 32,
  parameter int unsigned NWORDS = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rmt_we_i,
  input  logic [OFF_W-1:0] rmt_off_i,
  input  logic [DW-1:0]    rmt_wdata_i,
  input  logic             hst_we_i,
  input  logic [OFF_W-1:0] hst_off_i,
  input  logic [DW-1:0]    hst_wdata_i,
  output logic [DW-1:0]    rd_data_o,
  output logic             evt_o
);
  localparam int unsigned DBW = 8;

  slot_t rs, hs;
  logic  rmt_hit, hst_hit, db_wr;
  logic [DW-1:0]  words_q [NWORDS];
  logic [DBW-1:0] db_q;

  assign rs      = dec_slot(rmt_off_i);
  assign hs      = dec_slot(hst_off_i);
  assign rmt_hit = rmt_we_i & rs.hit;
  assign hst_hit = hst_we_i & hs.hit;
  assign db_wr   = rmt_hit && (rs.slot == 4'd0);
  assign evt_o   = db_wr && (rmt_wdata_i[DB_MSG_BIT] || rmt_wdata_i[DB_ACK_BIT]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      db_q <= '0;
    end else if (db_wr) begin
      db_q <= rmt_wdata_i[DBW-1:0];
    end else begin
      db_q[DB_ACK_BIT:DB_MSG_BIT] <= '0;  // event bits self-clear
    end
  end

  for (genvar k = 0; k < NWORDS; k++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        words_q[k] <= '0;
      end else if (rmt_hit && rs.slot == 4'(k + 1)) begin
        words_q[k] <= rmt_wdata_i;  // remote wins over host
      end else if (hst_hit && hs.slot == 4'(k + 1)) begin
        words_q[k] <= hst_wdata_i;
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (hs.hit) begin
      if (hs.slot == 4'd0) rd_data_o = DW'(db_q);
      for (int k = 0; k < NWORDS; k++) begin
        if (hs.slot == 4'(k + 1)) rd_data_o = words_q[k];
      end
    end
  end

  AST_DB_SELF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((db_q[DB_ACK_BIT:DB_MSG_BIT] != 2'b00) && !db_wr) |=> (db_q[DB_ACK_BIT:DB_MSG_BIT] == 2'b00)); // R4
  AST_EVT_SEEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |=> (db_q[DB_MSG_BIT] || db_q[DB_ACK_BIT])); // R3
endmodule

// File: rtl/mbox_irq_ctrl.sv
module mbox_irq_ctrl #(
  parameter int unsigned NRMT = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NRMT-1:0] set_i,
  input  logic            clr_we_i,
  input  logic [NRMT-1:0] clr_bits_i,
  input  logic            mask_we_i,
  input  logic [NRMT-1:0] mask_bits_i,
  output logic [NRMT-1:0] status_o,
  output logic [NRMT-1:0] mask_o,
  output logic            irq_o
);
  logic [NRMT-1:0] status_q, mask_q, clr_eff;
  logic            irq_q;

  assign clr_eff = clr_we_i ? clr_bits_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      mask_q   <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= (status_q & ~clr_eff) | set_i;  // set wins
      if (mask_we_i) mask_q <= mask_bits_i;
      irq_q <= |(status_q & mask_q);
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign irq_o    = irq_q;

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((status_q & $past(set_i)) == $past(set_i))); // R6
  AST_STATUS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((set_i == '0) && !clr_we_i) |=> $stable(status_q)); // R3
  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_q & mask_q) == '0) |=> !irq_o); // R7
  AST_IRQ_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_q & mask_q) != '0) |=> irq_o); // R7
endmodule

// File: rtl/mbox_hub.sv
module mbox_hub
  import mbox_pkg::*;
#(
  parameter int unsigned DW     = 32,
  parameter int unsigned AW     = 16,
  parameter int unsigned NCH    = 4,
  parameter int unsigned NWORDS = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  hst_we_i,
  input  logic [AW-1:0]         hst_addr_i,
  input  logic [DW-1:0]         hst_wdata_i,
  output logic [DW-1:0]         hst_rdata_o,
  input  logic [NCH-2:0]        rmt_we_i,
  input  logic [(NCH-1)*6-1:0]  rmt_off_i,
  input  logic [(NCH-1)*DW-1:0] rmt_wdata_i,
  output logic                  irq_o
);
  localparam int unsigned NRMT   = NCH - 1;
  localparam int unsigned BANK_W = $clog2(NCH);
  localparam int unsigned BANK_L = 12;
  localparam int unsigned BANK_H = BANK_L + BANK_W;

  logic [OFF_W-1:0]  off;
  logic [BANK_W-1:0] bank;
  logic              clean, ctrl_sel;
  logic [NRMT-1:0]   link_sel, evt, status, mask;
  logic [DW-1:0]     link_rd [NRMT];

  assign off      = hst_addr_i[OFF_W-1:0];
  assign bank     = hst_addr_i[BANK_H-1:BANK_L];
  assign clean    = (hst_addr_i[AW-1:BANK_H] == '0) && (hst_addr_i[BANK_L-1:OFF_W] == '0);
  assign ctrl_sel = clean && (bank == '0);

  for (genvar n = 0; n < NRMT; n++) begin : g_link
    assign link_sel[n] = clean && (bank == BANK_W'(n + 1));

    mbox_link #(.DW(DW), .NWORDS(NWORDS)) u_link (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .rmt_we_i    (rmt_we_i[n]),
      .rmt_off_i   (rmt_off_i[n*OFF_W +: OFF_W]),
      .rmt_wdata_i (rmt_wdata_i[n*DW +: DW]),
      .hst_we_i    (hst_we_i && link_sel[n]),
      .hst_off_i   (off),
      .hst_wdata_i (hst_wdata_i),
      .rd_data_o   (link_rd[n]),
      .evt_o       (evt[n])
    );
  end

  mbox_irq_ctrl #(.NRMT(NRMT)) u_irq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_i       (evt),
    .clr_we_i    (hst_we_i && ctrl_sel && (off == OFF_CLR)),
    .clr_bits_i  (hst_wdata_i[NRMT-1:0]),
    .mask_we_i   (hst_we_i && ctrl_sel && (off == OFF_MASK)),
    .mask_bits_i (hst_wdata_i[NRMT-1:0]),
    .status_o    (status),
    .mask_o      (mask),
    .irq_o       (irq_o)
  );

  always_comb begin
    hst_rdata_o = '0;
    if (ctrl_sel) begin
      if (off == OFF_STAT) hst_rdata_o = DW'(status);
      if (off == OFF_MASK) hst_rdata_o = DW'(mask);
    end
    for (int n = 0; n < NRMT; n++) begin
      if (link_sel[n]) hst_rdata_o = link_rd[n];
    end
  end
endmodule

// File: tb/mbox_hub_tb.sv
`timescale 1ns/1ps
module mbox_hub_tb_top;
  localparam int DW = 32;
  localparam int NRMT = 3;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 hst_we = 1'b0;
  logic [15:0]          hst_addr = '0;
  logic [DW-1:0]        hst_wdata = '0;
  logic [DW-1:0]        hst_rdata;
  logic [NRMT-1:0]      rmt_we = '0;
  logic [NRMT*6-1:0]    rmt_off = '0;
  logic [NRMT*DW-1:0]   rmt_wdata = '0;
  logic                 irq;
  int                   n_chk = 0;
  int                   n_err = 0;

  always #2.5 clk = ~clk;

  mbox_hub dut_i (
    .clk_i(clk), .rst_ni(rst_n), .hst_we_i(hst_we), .hst_addr_i(hst_addr),
    .hst_wdata_i(hst_wdata), .hst_rdata_o(hst_rdata), .rmt_we_i(rmt_we),
    .rmt_off_i(rmt_off), .rmt_wdata_i(rmt_wdata), .irq_o(irq)
  );

  task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [15:0] a, output logic [DW-1:0] d);
    hst_addr = a;
    #1;
    d = hst_rdata;
  endtask

  task automatic chk_rd(input logic [15:0] a, input logic [DW-1:0] exp, input string req);
    logic [DW-1:0] d;
    rd(a, d);
    chk(d, exp, req);
  endtask

  // drive at negedge, commit at posedge, return at the next negedge
  task automatic cycle(input logic hw, input logic [15:0] ha, input logic [DW-1:0] hd,
                       input int ln, input logic [5:0] ro, input logic [DW-1:0] rdt);
    hst_we = hw; hst_addr = ha; hst_wdata = hd;
    if (ln >= 0) begin
      rmt_we[ln] = 1'b1; rmt_off[ln*6 +: 6] = ro; rmt_wdata[ln*DW +: DW] = rdt;
    end
    @(posedge clk);
    @(negedge clk);
    hst_we = 1'b0; rmt_we = '0;
  endtask

  task automatic hwr(input logic [15:0] a, input logic [DW-1:0] d);
    cycle(1'b1, a, d, -1, '0, '0);
  endtask

  task automatic rwr(input int ln, input logic [5:0] o, input logic [DW-1:0] d);
    cycle(1'b0, 16'h0, '0, ln, o, d);
  endtask

  task automatic idle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk_rd(16'h0000, 0, "R1 status");
    chk_rd(16'h000C, 0, "R1 mask");
    chk(DW'(irq), 0, "R1 irq");
    for (int n = 1; n <= 3; n++) begin
      chk_rd(16'(n << 12) | 16'h10, 0, "R1 doorbell");
      chk_rd(16'(n << 12) | 16'h14, 0, "R1 word0");
      chk_rd(16'(n << 12) | 16'h30, 0, "R1 word7");
    end
  endtask

  task automatic t_words();
    for (int n = 0; n < 3; n++)
      for (int k = 0; k < 8; k++) rwr(n, 6'(8'h14 + 4 * k), 32'hA000_0000 | (n << 8) | k);
    for (int n = 0; n < 3; n++)
      for (int k = 0; k < 8; k++)
        chk_rd(16'((n + 1) << 12) | 16'(8'h14 + 4 * k), 32'hA000_0000 | (n << 8) | k, "R2 word");
    hwr(16'h1014, 0);
    chk_rd(16'h1014, 0, "R8 zero word0");
    hwr(16'h3030, 32'h1234_5678);
    chk_rd(16'h3030, 32'h1234_5678, "R8 host word7");
    chk_rd(16'h3014, 32'hA000_0200, "R8 neighbour kept");
  endtask

  task automatic t_doorbell();
    rwr(0, 6'h10, 32'h0000_0043);
    chk_rd(16'h0000, 32'h1, "R3 status link1");
    chk_rd(16'h1010, 32'h43, "R4 doorbell pulse");
    idle();
    chk_rd(16'h1010, 32'h03, "R4 self clear");
    chk_rd(16'h0000, 32'h1, "R3 status holds");
    hwr(16'h1010, 32'hFF);
    chk_rd(16'h1010, 32'h03, "R4 host write no effect");
    chk_rd(16'h0000, 32'h1, "R4 host doorbell no status");
    rwr(2, 6'h10, 32'h0000_0080);
    chk_rd(16'h0000, 32'h5, "R3 ack link3 bit2");
    rwr(1, 6'h10, 32'h0000_003F);
    chk_rd(16'h0000, 32'h5, "R11 no event bits");
  endtask

  task automatic t_clear();
    hwr(16'h0004, 32'h1);
    chk_rd(16'h0000, 32'h4, "R5 partial clear");
    chk_rd(16'h0004, 0, "R5 clear reads zero");
    rwr(1, 6'h10, 32'h40);
    hwr(16'h0004, 32'hFF);
    chk_rd(16'h0000, 0, "R5 clear all");
    rwr(0, 6'h10, 32'h40);
    cycle(1'b1, 16'h0004, 32'h1, 0, 6'h10, 32'h40);
    chk_rd(16'h0000, 32'h1, "R6 set wins");
    hwr(16'h0004, 32'hFF);
  endtask

  task automatic t_irq();
    hwr(16'h000C, 32'h2);
    chk_rd(16'h000C, 32'h2, "R7 mask readback");
    rwr(0, 6'h10, 32'h40);
    idle(); idle();
    chk(DW'(irq), 0, "R7 masked link stays quiet");
    rwr(1, 6'h10, 32'h40);
    chk(DW'(irq), 0, "R7 irq one cycle late");
    idle();
    chk(DW'(irq), 1, "R7 irq raised");
    hwr(16'h0004, 32'h2);
    chk(DW'(irq), 1, "R7 irq lag on clear");
    idle();
    chk(DW'(irq), 0, "R7 irq dropped");
    hwr(16'h000C, 32'h1);
    idle();
    chk(DW'(irq), 1, "R7 unmask pending");
    hwr(16'h000C, 32'h0);
    idle();
    chk(DW'(irq), 0, "R7 mask off");
    hwr(16'h0004, 32'hFF);
  endtask

  task automatic t_unmapped();
    chk_rd(16'h0008, 0, "R9 bank0 hole");
    chk_rd(16'h1000, 0, "R9 bank1 no status");
    chk_rd(16'h1034, 0, "R9 past word7");
    chk_rd(16'h1016, 0, "R9 misaligned");
    chk_rd(16'h5014, 0, "R9 above map");
    hwr(16'h0014, 32'hDEAD_BEAF);
    chk_rd(16'h0014, 0, "R9 bank0 word ignored");
    hwr(16'h5014, 32'hDEAD_BEAF);
    chk_rd(16'h1014, 0, "R9 alias ignored");
    hwr(16'h0008, 32'h7);
    chk_rd(16'h000C, 0, "R9 mask untouched");
    rwr(0, 6'h0C, 32'h7);
    chk_rd(16'h0000, 0, "R9 remote stray no status");
    rwr(0, 6'h34, 32'h5555_5555);
    chk_rd(16'h1030, 32'hA000_0007, "R9 remote stray ignored");
  endtask

  task automatic t_race();
    cycle(1'b1, 16'h2020, 32'h1111_1111, 1, 6'h20, 32'h2222_2222);
    chk_rd(16'h2020, 32'h2222_2222, "R10 remote wins");
  endtask

  initial begin
    #2000000;
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_words();
    t_doorbell();
    t_clear();
    t_irq();
    t_unmapped();
    t_race();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule